// File: doc/BRIEF.md
# Operand Bypass Select Logic

This block is the forwarding controller for the register-read stage of a four-stage pipeline. For each of the two source operands of the instruction being read, it decides where the operand value comes from. There are three choices. The first is the register-file read port. The second is the result leaving the ALU stage. The third is the value the write-back stage is storing into the register file during this same cycle. The register file cannot return a value it is still writing, which is why the third path exists.

The decision is purely combinational. It compares register numbers across the stages and qualifies each match by the class of the opcodes involved. A result from the ALU stage is forwarded only if that instruction is a computational operation. A load in the ALU stage has no data ready yet, so a dependency on it raises a hazard flag for the stall logic. The always-zero register is never forwarded. When both later stages match, the younger ALU-stage result wins.

Top module: `operand_bypass_sel`

## Requirements
- R1: Each select output is encoded as 0 for register-file data, 1 for the ALU-stage result and 2 for the write-back value. The code 3 is never produced.
- R2: An operand takes the ALU-stage result only when all four of these hold: the read-stage instruction reads that operand, the ALU-stage opcode is a computational operation (opcode bits [5:4] equal 2'b10 for the register form or 2'b11 for the constant form), the source register equals the ALU-stage destination, and the source is not register 31.
- R3: Operand A is read by opcodes with bits [5:4] of 2'b10 or 2'b11, and by the opcodes 0x18 (load), 0x19 (store), 0x1B (jump) and 0x1D (branch). Operand B is read only by opcodes with bits [5:4] of 2'b10 and by 0x19. Any other opcode reads neither operand, and its selects are 0.
- R4: A source register equal to 31 always yields select 0, whatever the later stages hold.
- R5: An operand takes the write-back value when all of these hold: the ALU path is not chosen, the operand is read, the source is not register 31, the write enable is 1, and the source equals the write address.
- R6: When a source matches both the ALU-stage destination (with a qualifying opcode) and an enabled write-back address, the ALU path (select 1) is chosen.
- R7: Operand B is decided from its own source field by the same rules as operand A, independently of operand A.
- R8: A load (opcode 0x18) in the ALU stage never yields select 1. The hazard output is 1 exactly when the ALU-stage opcode is 0x18 and some operand that is read, whose source is not register 31, equals the ALU-stage destination.
- R9: An operand with no qualifying match on any path gets select 0, which passes register-file data through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rfOpcode | input | 6 | Opcode of the instruction in the register-read stage |
| rfSrcA | input | 5 | First source register number of that instruction |
| rfSrcB | input | 5 | Second source register number of that instruction |
| aluOpcode | input | 6 | Opcode of the instruction in the ALU stage |
| aluDest | input | 5 | Destination register of the ALU-stage instruction |
| wbEnable | input | 1 | Register-file write enable in the write-back stage |
| wbAddr | input | 5 | Register-file write address in the write-back stage |
| selA | output | 2 | Source select for operand A |
| selB | output | 2 | Source select for operand B |
| loadHazard | output | 1 | Read-stage operand depends on a load in the ALU stage |

## Verification
Assertions inside the RTL check the following on every evaluation. A select is never 3. Register 31 is never forwarded. A qualifying ALU match always wins over write-back. A load in the ALU stage never produces the ALU select.

Some behaviours can only be shown by the bench's scenarios, which compare against an independent model. These are the exact operand-reading table per opcode, the write-back path firing only when enabled and matching, the independence of operand B from operand A, and the hazard flag rising exactly for load dependencies.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  localparam int OPC_W = 6;

  // select codes driven onto the operand muxes
  localparam logic [1:0] SEL_RF  = 2'd0;
  localparam logic [1:0] SEL_ALU = 2'd1;
  localparam logic [1:0] SEL_WB  = 2'd2;

  // opcode class fields and specific opcodes
  localparam logic [1:0]       CLS_ALU_REG   = 2'b10;
  localparam logic [1:0]       CLS_ALU_CONST = 2'b11;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 6'h18;
  localparam logic [OPC_W-1:0] OPC_STORE  = 6'h19;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 6'h1B;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 6'h1D;

  // strobes from the opcode decoder to the comparison datapath
  typedef struct packed {
    logic readsA;
    logic readsB;
    logic aluResult;
    logic aluLoad;
  } stageStrobes_t;

endpackage

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
(
  input  logic [OPC_W-1:0] rfOpcode,
  input  logic [OPC_W-1:0] aluOpcode,
  output stageStrobes_t    strobes
);

  logic [1:0] rfClass;
  logic [1:0] aluClass;
  logic       rfIsAlu;
  logic       rfIsAluReg;
  logic       rfSingleA;

  assign rfClass  = rfOpcode[OPC_W-1 -: 2];
  assign aluClass = aluOpcode[OPC_W-1 -: 2];

  always_comb begin
    rfIsAluReg = (rfClass == CLS_ALU_REG);
    rfIsAlu    = rfIsAluReg || (rfClass == CLS_ALU_CONST);
    rfSingleA  = (rfOpcode == OPC_LOAD) || (rfOpcode == OPC_JUMP) ||
                 (rfOpcode == OPC_BRANCH);

    strobes.readsA    = rfIsAlu || rfSingleA || (rfOpcode == OPC_STORE);
    strobes.readsB    = rfIsAluReg || (rfOpcode == OPC_STORE);
    strobes.aluResult = (aluClass == CLS_ALU_REG) || (aluClass == CLS_ALU_CONST);
    strobes.aluLoad   = (aluOpcode == OPC_LOAD);
  end

  // R3: an instruction that reads B always reads A as well
  always_comb begin
    assert_b_implies_a_R3: assert (!strobes.readsB || strobes.readsA)
      else $error("operand B read without operand A");
  end

endmodule

// File: rtl/bypass_datapath.sv
module bypass_datapath
  import bypass_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int NUM_OPS  = 2,
  parameter int ZERO_REG = 31
) (
  input  stageStrobes_t                  strobes,
  input  logic [NUM_OPS-1:0][REG_W-1:0]  srcRegs,
  input  logic [REG_W-1:0]               aluDest,
  input  logic                           wbEnable,
  input  logic [REG_W-1:0]               wbAddr,
  output logic [NUM_OPS-1:0][1:0]        selVec,
  output logic [NUM_OPS-1:0]             loadHitVec
);

  localparam logic [REG_W-1:0] ZERO_IDX = REG_W'(ZERO_REG);

  for (genvar g = 0; g < NUM_OPS; g++) begin : gOperand
    logic operandRead;
    logic notZero;
    logic aluMatch;
    logic wbMatch;
    logic aluHit;
    logic wbHit;

    if (g == 0) begin : gReadA
      assign operandRead = strobes.readsA;
    end else begin : gReadB
      assign operandRead = strobes.readsB;
    end

    always_comb begin
      notZero  = (srcRegs[g] != ZERO_IDX);
      aluMatch = (srcRegs[g] == aluDest);
      wbMatch  = (srcRegs[g] == wbAddr);
      aluHit   = operandRead && notZero && aluMatch && strobes.aluResult;
      wbHit    = operandRead && notZero && wbMatch && wbEnable && !aluHit;
      loadHitVec[g] = operandRead && notZero && aluMatch && strobes.aluLoad;

      if (aluHit)     selVec[g] = SEL_ALU;
      else if (wbHit) selVec[g] = SEL_WB;
      else            selVec[g] = SEL_RF;
    end

    always_comb begin
      assert_sel_legal_R1: assert (selVec[g] != 2'd3)
        else $error("illegal select code");
      assert_no_zero_R4: assert (srcRegs[g] != ZERO_IDX || selVec[g] == SEL_RF)
        else $error("zero register forwarded");
      assert_alu_priority_R6: assert (!(operandRead && notZero && aluMatch &&
                                        strobes.aluResult) || selVec[g] == SEL_ALU)
        else $error("ALU match not given priority");
      assert_unread_rf_R9: assert (operandRead || selVec[g] == SEL_RF)
        else $error("unread operand forwarded");
    end
  end

endmodule

// File: rtl/operand_bypass_sel.sv
module operand_bypass_sel
  import bypass_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int ZERO_REG = 31
) (
  input  logic [OPC_W-1:0] rfOpcode,
  input  logic [REG_W-1:0] rfSrcA,
  input  logic [REG_W-1:0] rfSrcB,
  input  logic [OPC_W-1:0] aluOpcode,
  input  logic [REG_W-1:0] aluDest,
  input  logic             wbEnable,
  input  logic [REG_W-1:0] wbAddr,
  output logic [1:0]       selA,
  output logic [1:0]       selB,
  output logic             loadHazard
);

  localparam int NUM_OPS = 2;

  stageStrobes_t                 strobes;
  logic [NUM_OPS-1:0][REG_W-1:0] srcRegs;
  logic [NUM_OPS-1:0][1:0]       selVec;
  logic [NUM_OPS-1:0]            loadHitVec;

  assign srcRegs[0] = rfSrcA;
  assign srcRegs[1] = rfSrcB;

  bypass_ctrl i_ctrl (
    .rfOpcode  (rfOpcode),
    .aluOpcode (aluOpcode),
    .strobes   (strobes)
  );

  bypass_datapath #(
    .REG_W    (REG_W),
    .NUM_OPS  (NUM_OPS),
    .ZERO_REG (ZERO_REG)
  ) i_datapath (
    .strobes    (strobes),
    .srcRegs    (srcRegs),
    .aluDest    (aluDest),
    .wbEnable   (wbEnable),
    .wbAddr     (wbAddr),
    .selVec     (selVec),
    .loadHitVec (loadHitVec)
  );

  assign selA       = selVec[0];
  assign selB       = selVec[1];
  assign loadHazard = |loadHitVec;

  always_comb begin
    assert_load_no_alu_R8: assert (aluOpcode != OPC_LOAD ||
                                   (selA != SEL_ALU && selB != SEL_ALU))
      else $error("load result forwarded from ALU stage");
    assert_hazard_only_load_R8: assert (!loadHazard || aluOpcode == OPC_LOAD)
      else $error("hazard without load in ALU stage");
  end

endmodule

// File: tb/test_operand_bypass_sel.sv
module test_operand_bypass_sel;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] rfOpcode = '0;
  logic [4:0] rfSrcA = '0;
  logic [4:0] rfSrcB = '0;
  logic [5:0] aluOpcode = '0;
  logic [4:0] aluDest = '0;
  logic       wbEnable = 1'b0;
  logic [4:0] wbAddr = '0;
  logic [1:0] selA;
  logic [1:0] selB;
  logic       loadHazard;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       h;
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];

  always #5 clk = ~clk;

  operand_bypass_sel i_operand_bypass_sel (
    .rfOpcode   (rfOpcode),
    .rfSrcA     (rfSrcA),
    .rfSrcB     (rfSrcB),
    .aluOpcode  (aluOpcode),
    .aluDest    (aluDest),
    .wbEnable   (wbEnable),
    .wbAddr     (wbAddr),
    .selA       (selA),
    .selB       (selB),
    .loadHazard (loadHazard)
  );

  // reference model built from the requirement text (R3 table)
  function automatic bit readsA(logic [5:0] op);
    return op[5:4] == 2'b10 || op[5:4] == 2'b11 || op == 6'h18 ||
           op == 6'h19 || op == 6'h1B || op == 6'h1D;
  endfunction

  function automatic bit readsB(logic [5:0] op);
    return op[5:4] == 2'b10 || op == 6'h19;
  endfunction

  function automatic logic [1:0] modelSel(bit rd, logic [4:0] src, logic [5:0] aop,
                                          logic [4:0] ad, logic we, logic [4:0] wa);
    if (!rd || src == 5'd31) return 2'd0;
    if (aop[5] && src == ad) return 2'd1;
    if (we && src == wa) return 2'd2;
    return 2'd0;
  endfunction

  task automatic apply(logic [5:0] op, logic [4:0] sa, logic [4:0] sb,
                       logic [5:0] aop, logic [4:0] ad, logic we,
                       logic [4:0] wa, string tag);
    expItem_t it;
    @(posedge clk);
    #1;
    rfOpcode = op; rfSrcA = sa; rfSrcB = sb;
    aluOpcode = aop; aluDest = ad; wbEnable = we; wbAddr = wa;
    it.a = modelSel(readsA(op), sa, aop, ad, we, wa);
    it.b = modelSel(readsB(op), sb, aop, ad, we, wa);
    it.h = (aop == 6'h18) &&
           ((readsA(op) && sa != 5'd31 && sa == ad) ||
            (readsB(op) && sb != 5'd31 && sb == ad));
    it.tag = tag;
    scoreQ.push_back(it);
  endtask

  // monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      expItem_t e;
      e = scoreQ.pop_front();
      checks += 3;
      if (selA !== e.a) begin
        failures++;
        $display("FAIL %s selA actual=%0d expected=%0d", e.tag, selA, e.a);
      end
      if (selB !== e.b) begin
        failures++;
        $display("FAIL %s selB actual=%0d expected=%0d", e.tag, selB, e.b);
      end
      if (loadHazard !== e.h) begin
        failures++;
        $display("FAIL %s loadHazard actual=%0d expected=%0d", e.tag, loadHazard, e.h);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [5:0] OPS [10] = '{6'h20, 6'h27, 6'h30, 6'h3A, 6'h18,
                                     6'h19, 6'h1B, 6'h1D, 6'h00, 6'h1A};

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // R9: idle state with no forwarding
    apply(6'h00, 5'd0, 5'd0, 6'h00, 5'd0, 1'b0, 5'd0, "R9 idle");
    // R2: register-form ALU producer, operand A match
    apply(6'h20, 5'd3, 5'd4, 6'h21, 5'd3, 1'b0, 5'd0, "R2 alu A");
    // R2: constant-form ALU producer, operand B match
    apply(6'h22, 5'd1, 5'd7, 6'h31, 5'd7, 1'b0, 5'd0, "R2 const B");
    // R5: write-back match on A
    apply(6'h30, 5'd9, 5'd9, 6'h00, 5'd2, 1'b1, 5'd9, "R5 wb A");
    // R5: write-back address matches but enable low
    apply(6'h20, 5'd9, 5'd8, 6'h00, 5'd2, 1'b0, 5'd9, "R5 wb disabled");
    // R6: both paths match, ALU wins
    apply(6'h20, 5'd5, 5'd5, 6'h2F, 5'd5, 1'b1, 5'd5, "R6 priority");
    // R4: register 31 everywhere
    apply(6'h20, 5'd31, 5'd31, 6'h20, 5'd31, 1'b1, 5'd31, "R4 zero reg");
    // R3: constant form does not read B
    apply(6'h30, 5'd1, 5'd6, 6'h20, 5'd6, 1'b1, 5'd6, "R3 const no B");
    // R3: store reads B
    apply(6'h19, 5'd1, 5'd6, 6'h20, 5'd6, 1'b0, 5'd0, "R3 store B");
    // R3: unlisted opcode reads nothing
    apply(6'h1A, 5'd4, 5'd4, 6'h20, 5'd4, 1'b1, 5'd4, "R3 no read");
    // R8: load in ALU stage, dependent A -> hazard, falls to write-back
    apply(6'h20, 5'd12, 5'd1, 6'h18, 5'd12, 1'b1, 5'd12, "R8 load hazard");
    // R8: load in ALU stage, no dependency
    apply(6'h20, 5'd12, 5'd1, 6'h18, 5'd13, 1'b0, 5'd0, "R8 load clear");
    // R8: load dependency through register 31 is ignored
    apply(6'h20, 5'd31, 5'd31, 6'h18, 5'd31, 1'b0, 5'd0, "R8 load zero");
    // R7: A from ALU, B from write-back
    apply(6'h21, 5'd2, 5'd3, 6'h2A, 5'd2, 1'b1, 5'd3, "R7 split");
    // R1: random mix, selects checked against the model
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] pool [4];
      pool = '{5'd1, 5'd2, 5'd31, 5'($urandom_range(0, 31))};
      apply(OPS[$urandom_range(0, 9)], pool[$urandom_range(0, 3)],
            pool[$urandom_range(0, 3)], OPS[$urandom_range(0, 9)],
            pool[$urandom_range(0, 3)], 1'($urandom_range(0, 1)),
            pool[$urandom_range(0, 3)], "R1 R7 random");
    end
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule